// File: doc/BRIEF.md
# Key Wakeup Request Detector

This block watches a small set of external key lines and turns them into a single request toward the clock and power controller. Every key has its own enable and its own choice of active condition: a low or high level, or a falling or rising edge. Each key line is synchronized with two flops before detection. A detected event sets a sticky pending bit for that key. The combined request is the OR of the pending bits of the keys that are currently enabled.

Software programs the block over a small write-only register bus. There is one control register per key, a global use-select bit and a clear register. The clear register acts only when a fixed 4-bit code is written, and it drops every pending key together. When the use-select bit routes the keys to stop-state release, any enabled key held at its active level drives the request through a path with no registers. The controller can therefore be woken while the system clock is stopped.

Top module: `keywake_ctrl`

## Requirements
- R1: After reset all keys are disabled, use their low-level condition, the use-select bit is 0, `pend_o` is 0 and `kw_req` is 0.
- R2: A key whose enable bit is 0 never sets its pending bit, whatever its input does.
- R3: Level conditions: code 2'b00 treats a low input as active, and code 2'b01 treats a high input as active. An input change made between clock edges shows in `pend_o` after the third following rising edge (two synchronizer flops, then the pending register).
- R4: Edge conditions: code 2'b10 detects a high-to-low change and code 2'b11 detects a low-to-high change of the synchronized input, with the same three-edge latency as R3. A change in the opposite direction sets nothing.
- R5: Each key's control register sits at bus address equal to the key number, with bit 0 the enable and bits 2:1 the condition code. `kw_req` is high exactly when some key is both pending and enabled, so disabling a pending key masks it while its pending bit stays visible.
- R6: A pending bit stays set after its key input returns to inactive, until a clear.
- R7: A write to address NKEYS+1 with `bus_wdata` equal to 4'b1010 clears pending bits on that clock edge. Any other written value leaves them unchanged.
- R8: A single clear removes every pending bit at once, with no per-key clear.
- R9: If a key event and a clear land on the same clock edge, that key's pending bit is set afterwards.
- R10: Bit 0 written to address NKEYS is the use-select bit. When it is 1, an enabled key whose raw input is at its selected active level drives `kw_req` high with no clock edge in between. When it is 0, `kw_req` follows only the pending bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| key_in | input | NKEYS | Raw external key lines |
| bus_wr | input | 1 | Register write strobe, sampled on the rising edge |
| bus_addr | input | AW | Register address |
| bus_wdata | input | 4 | Register write data |
| kw_req | output | 1 | Combined wake / interrupt request, active high |
| pend_o | output | NKEYS | Pending bit of each key |

## Verification
The bench builds the block with its defaults: four keys and two synchronizer stages. With these values the clear register sits at address 5, and the three-edge latency from an input change to a pending bit can be counted exactly. That exact count allows a key edge to be placed on the same clock edge as a clear write, which is the race described in R9. Four keys are enough to hold several pending bits at once for the shared clear, and to mask one key while the others stay untouched.

// File: rtl/kw_pkg.sv
package kw_pkg;

  typedef enum logic [1:0] {
    KC_LOW  = 2'b00,
    KC_HIGH = 2'b01,
    KC_FALL = 2'b10,
    KC_RISE = 2'b11
  } kcond_e;

  localparam logic [3:0] CLR_CODE = 4'b1010;

  // condition met on the synchronized input (cur) given its previous value
  function automatic logic cond_hit(kcond_e c, logic cur, logic prev);
    unique case (c)
      KC_LOW:  return ~cur;
      KC_HIGH: return cur;
      KC_FALL: return prev & ~cur;
      default: return ~prev & cur;
    endcase
  endfunction

  // level-only test on a raw input, used by the clockless wake path
  function automatic logic level_hit(kcond_e c, logic raw);
    return ((c == KC_LOW) & ~raw) | ((c == KC_HIGH) & raw);
  endfunction

endpackage

// File: rtl/kw_sync.sv
module kw_sync #(
  parameter int N      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d[i]};
    end
    assign q[i] = chain[STAGES-1];
  end
endmodule

// File: rtl/kw_detect.sv
module kw_detect
  import kw_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [1:0] cond,
  input  logic       s,
  output logic       evt
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= s;
  end

  assign evt = en & cond_hit(kcond_e'(cond), s, prev_q);
endmodule

// File: rtl/kw_regs.sv
module kw_regs
  import kw_pkg::*;
#(
  parameter int N  = 4,
  parameter int AW = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [AW-1:0]     bus_addr,
  input  logic [3:0]        bus_wdata,
  output logic [N-1:0]      key_en,
  output logic [N-1:0][1:0] key_cond,
  output logic              glob_mode,
  output logic              clr_hit
);
  localparam logic [AW-1:0] MODE_ADDR = AW'(N);
  localparam logic [AW-1:0] CLR_ADDR  = AW'(N + 1);

  for (genvar i = 0; i < N; i++) begin : g_key
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        key_en[i]   <= 1'b0;
        key_cond[i] <= KC_LOW;
      end else if (bus_wr && bus_addr == AW'(i)) begin
        key_en[i]   <= bus_wdata[0];
        key_cond[i] <= bus_wdata[2:1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                glob_mode <= 1'b0;
    else if (bus_wr && bus_addr == MODE_ADDR)  glob_mode <= bus_wdata[0];
  end

  assign clr_hit = bus_wr && (bus_addr == CLR_ADDR) && (bus_wdata == CLR_CODE);
endmodule

// File: rtl/keywake_ctrl.sv
module keywake_ctrl
  import kw_pkg::*;
#(
  parameter  int NKEYS       = 4,
  parameter  int SYNC_STAGES = 2,
  localparam int AW          = $clog2(NKEYS + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NKEYS-1:0] key_in,
  input  logic             bus_wr,
  input  logic [AW-1:0]    bus_addr,
  input  logic [3:0]       bus_wdata,
  output logic             kw_req,
  output logic [NKEYS-1:0] pend_o
);
  logic [NKEYS-1:0]      key_en;
  logic [NKEYS-1:0][1:0] key_cond;
  logic                  glob_mode;
  logic                  clr_hit;
  logic [NKEYS-1:0]      key_s;
  logic [NKEYS-1:0]      key_evt;
  logic [NKEYS-1:0]      lvl_raw;
  logic [NKEYS-1:0]      pend_q;
  logic                  pend_req;
  logic                  async_req;

  kw_regs #(.N(NKEYS), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .key_en(key_en), .key_cond(key_cond),
    .glob_mode(glob_mode), .clr_hit(clr_hit)
  );

  kw_sync #(.N(NKEYS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(key_in), .q(key_s)
  );

  for (genvar i = 0; i < NKEYS; i++) begin : g_det
    kw_detect u_det (
      .clk(clk), .rst_n(rst_n), .en(key_en[i]), .cond(key_cond[i]),
      .s(key_s[i]), .evt(key_evt[i])
    );
    assign lvl_raw[i] = key_en[i] & level_hit(kcond_e'(key_cond[i]), key_in[i]);
  end

  // new events take priority over a clear on the same edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (clr_hit ? '0 : pend_q) | key_evt;
  end

  assign pend_req  = |(pend_q & key_en);
  assign async_req = glob_mode & (|lvl_raw);
  assign kw_req    = pend_req | async_req;
  assign pend_o    = pend_q;
endmodule

// File: rtl/kw_checker.sv
module kw_checker #(
  parameter int N = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] pend_o,
  input logic         kw_req,
  input logic [N-1:0] key_en,
  input logic         glob_mode,
  input logic         clr_hit,
  input logic [N-1:0] key_evt
);
  p_disabled_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_o & ~$past(pend_o) & ~$past(key_en)) == '0));

  p_req_masked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !glob_mode |-> (kw_req == (|(pend_o & key_en))));

  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_hit |=> ((pend_o & $past(pend_o)) == $past(pend_o)));

  p_clear_all_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_hit |=> ((pend_o & ~$past(key_evt)) == '0));

  p_event_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|key_evt) |=> ((pend_o & $past(key_evt)) == $past(key_evt)));

  p_pend_drives_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (|(pend_o & key_en)) |-> kw_req);
endmodule

bind keywake_ctrl kw_checker #(.N(NKEYS)) u_chk (
  .clk(clk), .rst_n(rst_n), .pend_o(pend_o), .kw_req(kw_req),
  .key_en(key_en), .glob_mode(glob_mode), .clr_hit(clr_hit),
  .key_evt(key_evt)
);

// File: tb/tb_keywake_ctrl.sv
`timescale 1ns/1ps
module tb_keywake_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] key_in = 4'hF;
  logic       bus_wr = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [3:0] bus_wdata = '0;
  logic       kw_req;
  logic [3:0] pend_o;

  int n_chk = 0;
  int n_fail = 0;

  typedef struct {
    string      tag;
    logic [3:0] pend;
    logic       req;
  } exp_t;
  exp_t sb[$];

  always #10 clk = ~clk;

  keywake_ctrl dut (
    .clk(clk), .rst_n(rst_n), .key_in(key_in), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .kw_req(kw_req), .pend_o(pend_o)
  );

  // driver side
  task automatic expect_now(string tag, logic [3:0] p, logic r);
    exp_t e;
    e.tag = tag; e.pend = p; e.req = r;
    sb.push_back(e);
  endtask

  task automatic set_keys(logic [3:0] v);
    @(negedge clk);
    key_in = v;
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic bus_write(logic [2:0] a, logic [3:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1;
    bus_wr = 1'b0;
  endtask

  // monitor side
  initial begin
    forever begin
      @(negedge clk);
      while (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        n_chk++;
        if (pend_o !== e.pend || kw_req !== e.req) begin
          n_fail++;
          $display("FAIL %s: pend=%b req=%b expected pend=%b req=%b",
                   e.tag, pend_o, kw_req, e.pend, e.req);
        end
      end
    end
  end

  initial begin
    #4000000;
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    expect_now("R1 in reset", 4'b0000, 1'b0);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1;
    expect_now("R1 after reset", 4'b0000, 1'b0);

    // R3 low level on key0
    bus_write(3'd0, 4'b0001);
    set_keys(4'b1110);
    settle();
    expect_now("R3 low level key0", 4'b0001, 1'b1);

    // R6 sticky
    set_keys(4'b1111);
    settle();
    repeat (2) @(posedge clk); #1;
    expect_now("R6 sticky key0", 4'b0001, 1'b1);

    // R7 wrong code ignored, then right code
    bus_write(3'd5, 4'b0101);
    expect_now("R7 wrong code ignored", 4'b0001, 1'b1);
    bus_write(3'd5, 4'b1010);
    expect_now("R7 clear code", 4'b0000, 1'b0);

    // R2 disabled key1
    set_keys(4'b1101);
    settle();
    set_keys(4'b1111);
    settle();
    expect_now("R2 disabled key quiet", 4'b0000, 1'b0);

    // R4 rising edge on key1
    bus_write(3'd1, 4'b0111);
    set_keys(4'b1101);
    settle();
    expect_now("R4 opposite edge no event", 4'b0000, 1'b0);
    set_keys(4'b1111);
    settle();
    expect_now("R4 rising key1", 4'b0010, 1'b1);

    // R4 falling edge on key2
    bus_write(3'd2, 4'b0101);
    set_keys(4'b1011);
    settle();
    expect_now("R4 falling key2", 4'b0110, 1'b1);

    // R8 single clear removes all
    bus_write(3'd5, 4'b1010);
    expect_now("R8 clear all", 4'b0000, 1'b0);

    // R3 high level on key3
    set_keys(4'b0011);
    settle();
    bus_write(3'd3, 4'b0011);
    @(negedge clk); #1;
    expect_now("R3 key3 low no event", 4'b0000, 1'b0);
    set_keys(4'b1011);
    settle();
    expect_now("R3 high level key3", 4'b1000, 1'b1);

    bus_write(3'd3, 4'b0000);
    bus_write(3'd5, 4'b1010);
    expect_now("R5 key3 disabled and cleared", 4'b0000, 1'b0);

    // R9 event and clear on the same edge
    set_keys(4'b1001);
    settle();
    @(posedge clk); #1;
    @(negedge clk) key_in = 4'b1011;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 3'd5; bus_wdata = 4'b1010;
    @(posedge clk); #1;
    bus_wr = 1'b0;
    expect_now("R9 event beats clear", 4'b0010, 1'b1);

    // R5 disable masks request
    bus_write(3'd1, 4'b0000);
    expect_now("R5 masked pending", 4'b0010, 1'b0);
    bus_write(3'd5, 4'b1010);
    expect_now("R8 clear masked bit", 4'b0000, 1'b0);

    // R10 mode 0: no clockless path
    @(negedge clk) key_in = 4'b1010;
    @(posedge clk); #1;
    expect_now("R10 mode0 no async req", 4'b0000, 1'b0);
    set_keys(4'b1011);
    settle();
    bus_write(3'd5, 4'b1010);
    expect_now("R10 cleared before mode1", 4'b0000, 1'b0);

    // R10 mode 1: combinational wake path
    bus_write(3'd4, 4'b0001);
    expect_now("R10 mode1 idle", 4'b0000, 1'b0);
    @(negedge clk) key_in = 4'b1010;
    #1;
    if (kw_req !== 1'b1) begin
      n_fail++;
      $display("FAIL R10 no-edge wake: req=%b expected 1", kw_req);
    end
    n_chk++;
    @(posedge clk); #1;
    expect_now("R10 mode1 async req", 4'b0000, 1'b1);

    @(negedge clk);
    @(negedge clk);
    while (sb.size() > 0) @(negedge clk);
    @(posedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule